// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the combinational integer stage of a small load/store core. In one pass it computes a sum, a difference, a bitwise function, a logical shift or a less-than test of two register operands. A 16-bit immediate can stand in for the second operand. How the immediate is widened depends on the operation: arithmetic and comparison forms copy the top bit into the upper half, and bitwise forms fill the upper half with zeros. A negative constant therefore gives a subtraction through the add path.

Only the signed sum and the signed difference can raise the overflow trap. Their unsigned forms give the same bit pattern and never trap. When the trap fires, or when the operation code is not defined, the write-enable output drops so that the destination register is left unchanged. Inside the block, a decoder turns the operation code into a small set of strobes, and a datapath uses those strobes to widen the immediate, run one shared adder, a staged shifter and the bitwise unit, and choose the result.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation codes (4 bits) are ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, NOR=6, SLT=7, SLTU=8, SLL=9, SRL=10. ADD returns A+B modulo 2^32 and raises `ovfTrap` when A and B have the same sign and the sum has the other sign.
- R2: ADDU and SUBU return the same result as ADD and SUB and never raise `ovfTrap`.
- R3: SUB returns A−B modulo 2^32 and raises `ovfTrap` when A and B differ in sign and the result's sign differs from A's sign.
- R4: When `immSel`=1 under ADD, ADDU, SUB, SUBU, SLT or SLTU, the second operand is `imm` sign-extended from bit 15 (0xFF9C acts as −100), and `opB` is ignored.
- R5: AND and OR return the bitwise function of A and B. When `immSel`=1 under AND, OR or NOR, the second operand is `imm` zero-extended (0x8001 becomes 0x00008001).
- R6: NOR returns ~(A|B), so NOR with a zero second operand gives ~A.
- R7: SLT returns 1 when A<B as two's-complement values and 0 otherwise. SLTU returns 1 when A<B as unsigned values. For A=0xFFFFFFFF and B=1, SLT gives 1 and SLTU gives 0.
- R8: SLL returns `opB` shifted left by `shamt` (0..31) with zeros filled in from the bottom. A shift of 0 returns `opB` unchanged. `immSel` and `opA` have no effect on the shift.
- R9: SRL returns `opB` shifted right by `shamt` with zeros filled in from the top (0x12345678 by 8 gives 0x00123456).
- R10: `wrEn` is 1 for a defined code without a trap and 0 when `ovfTrap` is 1. An undefined code (11..15) gives `result`=0, `ovfTrap`=0 and `wrEn`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand, and the shift source |
| imm | input | 16 | Immediate constant |
| immSel | input | 1 | Use the widened immediate as the second operand |
| shamt | input | 5 | Shift distance |
| opCode | input | 4 | Operation select |
| result | output | 32 | Computed value |
| ovfTrap | output | 1 | Signed overflow exception |
| wrEn | output | 1 | Destination write permission |

## Verification
The hard case is overflow on the immediate path. There the trap depends on the sign-extended constant and not on `opB`, so `opB` is loaded with values that would give a different outcome if the block used it by mistake. Signed overflow rarely occurs with random operands, so directed vectors sit on the 0x7FFFFFFF/0x80000000 boundary in both directions. Random operands are then forced into a same-sign or opposite-sign pairing so that traps happen often. The reference model computes overflow from 64-bit integer arithmetic and not from sign bits.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NOR  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_SLL  = 4'd9,
    OP_SRL  = 4'd10
  } alu_op_e;

  typedef enum logic [2:0] {
    RES_NONE  = 3'd0,
    RES_ARITH = 3'd1,
    RES_LOGIC = 3'd2,
    RES_CMP   = 3'd3,
    RES_SHIFT = 3'd4
  } res_sel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_NOR = 2'd2
  } log_fn_e;

  typedef struct packed {
    logic     useImm;
    logic     immZeroExt;
    logic     subMode;
    logic     trapEn;
    logic     cmpUnsigned;
    logic     shiftRight;
    logic     validOp;
    log_fn_e  logFn;
    res_sel_e resSel;
  } alu_strobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        immSel,
  output alu_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.logFn  = LOG_AND;
    strobe.resSel = RES_NONE;
    case (opCode)
      OP_ADD: begin
        strobe.validOp = 1'b1; strobe.trapEn = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_ARITH;
      end
      OP_ADDU: begin
        strobe.validOp = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_ARITH;
      end
      OP_SUB: begin
        strobe.validOp = 1'b1; strobe.trapEn = 1'b1; strobe.subMode = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_ARITH;
      end
      OP_SUBU: begin
        strobe.validOp = 1'b1; strobe.subMode = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_ARITH;
      end
      OP_AND: begin
        strobe.validOp = 1'b1; strobe.useImm = immSel; strobe.immZeroExt = 1'b1;
        strobe.logFn = LOG_AND; strobe.resSel = RES_LOGIC;
      end
      OP_OR: begin
        strobe.validOp = 1'b1; strobe.useImm = immSel; strobe.immZeroExt = 1'b1;
        strobe.logFn = LOG_OR; strobe.resSel = RES_LOGIC;
      end
      OP_NOR: begin
        strobe.validOp = 1'b1; strobe.useImm = immSel; strobe.immZeroExt = 1'b1;
        strobe.logFn = LOG_NOR; strobe.resSel = RES_LOGIC;
      end
      OP_SLT: begin
        strobe.validOp = 1'b1; strobe.subMode = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_CMP;
      end
      OP_SLTU: begin
        strobe.validOp = 1'b1; strobe.subMode = 1'b1; strobe.cmpUnsigned = 1'b1;
        strobe.useImm = immSel; strobe.resSel = RES_CMP;
      end
      OP_SLL: begin
        strobe.validOp = 1'b1; strobe.resSel = RES_SHIFT;
      end
      OP_SRL: begin
        strobe.validOp = 1'b1; strobe.shiftRight = 1'b1; strobe.resSel = RES_SHIFT;
      end
      default: strobe = strobe;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  alu_strobe_t         strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [IMM_W-1:0]    imm,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [DATA_W-1:0]   result,
  output logic                ovfFlag
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  // immediate widening
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] bEff;
  always_comb begin
    if (strobe.immZeroExt) immExt = {{EXT_W{1'b0}}, imm};
    else                   immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
    bEff = strobe.useImm ? immExt : opB;
  end

  // shared adder: A + B or A + ~B + 1
  logic [DATA_W-1:0] bAdd;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              rawOvf;
  always_comb begin
    bAdd     = strobe.subMode ? ~bEff : bEff;
    sumFull  = {1'b0, opA} + {1'b0, bAdd} + {{DATA_W{1'b0}}, strobe.subMode};
    sum      = sumFull[DATA_W-1:0];
    carryOut = sumFull[DATA_W];
    if (strobe.subMode)
      rawOvf = (opA[MSB] != bEff[MSB]) && (sum[MSB] != opA[MSB]);
    else
      rawOvf = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
    ovfFlag = strobe.trapEn && (strobe.resSel == RES_ARITH) && rawOvf;
  end

  // less-than from the difference
  logic lessThan;
  always_comb begin
    if (strobe.cmpUnsigned) lessThan = ~carryOut;
    else                    lessThan = sum[MSB] ^ rawOvf;
  end

  // bitwise unit
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (strobe.logFn)
      LOG_AND: logicRes = opA & bEff;
      LOG_OR:  logicRes = opA | bEff;
      LOG_NOR: logicRes = ~(opA | bEff);
      default: logicRes = '0;
    endcase
  end

  // staged logical shifter on opB
  logic [DATA_W-1:0] shStage [SHAMT_W+1];
  assign shStage[0] = opB;
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_shift
    localparam int DIST = 1 << s;
    always_comb begin
      if (!shamt[s])              shStage[s+1] = shStage[s];
      else if (strobe.shiftRight) shStage[s+1] = shStage[s] >> DIST;
      else                        shStage[s+1] = shStage[s] << DIST;
    end
  end

  always_comb begin
    case (strobe.resSel)
      RES_ARITH: result = sum;
      RES_LOGIC: result = logicRes;
      RES_CMP:   result = {{(DATA_W-1){1'b0}}, lessThan};
      RES_SHIFT: result = shStage[SHAMT_W];
      default:   result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({strobe, opA, opB, imm, shamt})) begin
      AST_SHIFT_ZERO_PASS: assert (!(strobe.resSel == RES_SHIFT && shamt == '0) || result == opB)
        else $error("zero shift altered operand"); // R8
      AST_NOR_DISJOINT: assert (!(strobe.resSel == RES_LOGIC && strobe.logFn == LOG_NOR) || ((result & opA) == '0))
        else $error("nor result overlaps operand"); // R6
      AST_ADD_MIXED_SIGN: assert (!(strobe.resSel == RES_ARITH && !strobe.subMode && opA[MSB] != bEff[MSB]) || !ovfFlag)
        else $error("mixed-sign add trapped"); // R1
      AST_SUB_SAME_SIGN: assert (!(strobe.resSel == RES_ARITH && strobe.subMode && opA[MSB] == bEff[MSB]) || !ovfFlag)
        else $error("same-sign subtract trapped"); // R3
    end
  end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm,
  input  logic               immSel,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [3:0]         opCode,
  output logic [DATA_W-1:0]  result,
  output logic               ovfTrap,
  output logic               wrEn
);
  alu_strobe_t strobe;
  logic        ovfFlag;

  alu_ctrl i_ctrl (
    .opCode (opCode),
    .immSel (immSel),
    .strobe (strobe)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_dp (
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .imm     (imm),
    .shamt   (shamt),
    .result  (result),
    .ovfFlag (ovfFlag)
  );

  assign ovfTrap = ovfFlag;
  assign wrEn    = strobe.validOp & ~ovfFlag;

  always_comb begin
    if (!$isunknown({opA, opB, imm, immSel, shamt, opCode})) begin
      AST_UNSIGNED_NO_TRAP: assert (!(opCode == OP_ADDU || opCode == OP_SUBU) || !ovfTrap)
        else $error("unsigned op trapped"); // R2
      AST_CMP_BOOLEAN: assert (!(opCode == OP_SLT || opCode == OP_SLTU) || result[DATA_W-1:1] == '0)
        else $error("compare result not 0/1"); // R7
      AST_UNDEF_QUIET: assert (opCode <= OP_SRL || (!wrEn && result == '0))
        else $error("undefined code wrote"); // R10
    end
  end
endmodule

// File: tb/test_alu_exec_unit.sv
module test_alu_exec_unit;
  logic        clk = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic        immSel = 1'b0;
  logic [4:0]  shamt = '0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;
  logic        ovfTrap, wrEn;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu_exec_unit i_alu_exec_unit (
    .opA(opA), .opB(opB), .imm(imm), .immSel(immSel), .shamt(shamt),
    .opCode(opCode), .result(result), .ovfTrap(ovfTrap), .wrEn(wrEn)
  );

  function automatic string tagOf(int op, bit isel);
    if (isel && (op <= 3 || op == 7 || op == 8)) return "R4";
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R2";
      4, 5: return "R5"; 6: return "R6"; 7, 8: return "R7";
      9: return "R8"; 10: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit isel, input int sh,
                       output logic [31:0] r, output bit ov, output bit we);
    logic [31:0] bv;
    longint sa, sb, sr;
    bv = b;
    if (isel && (op <= 3 || op == 7 || op == 8)) bv = {{16{im[15]}}, im};
    if (isel && (op >= 4 && op <= 6)) bv = {16'h0, im};
    sa = longint'($signed(a)); sb = longint'($signed(bv));
    ov = 0; r = '0; we = 1;
    case (op)
      0, 1: begin sr = sa + sb; r = a + bv; ov = (op == 0) && (sr > 64'sd2147483647 || sr < -64'sd2147483648); end
      2, 3: begin sr = sa - sb; r = a - bv; ov = (op == 2) && (sr > 64'sd2147483647 || sr < -64'sd2147483648); end
      4: r = a & bv;
      5: r = a | bv;
      6: r = ~(a | bv);
      7: r = (sa < sb) ? 32'd1 : 32'd0;
      8: r = (a < bv) ? 32'd1 : 32'd0;
      9: r = b << sh;
      10: r = b >> sh;
      default: begin r = '0; we = 0; end
    endcase
    if (ov) we = 0;
  endtask

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit isel, input int sh);
    logic [31:0] er; bit eo, ew; string tg;
    @(posedge clk); #1;
    opCode = op[3:0]; opA = a; opB = b; imm = im; immSel = isel; shamt = sh[4:0];
    @(negedge clk);
    model(op, a, b, im, isel, sh, er, eo, ew);
    tg = tagOf(op, isel);
    checks++;
    if (result !== er || ovfTrap !== eo || wrEn !== ew) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h isel=%0d sh=%0d: got res=%h ovf=%b we=%b exp res=%h ovf=%b we=%b",
               tg, op, a, b, im, isel, sh, result, ovfTrap, wrEn, er, eo, ew);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // initial state: ADD of zeros (R1/R10)
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || ovfTrap !== 1'b0 || wrEn !== 1'b1) begin
      failures++;
      $display("FAIL R10 initial: got res=%h ovf=%b we=%b exp res=0 ovf=0 we=1", result, ovfTrap, wrEn);
    end
    apply(0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0);          // R1 positive overflow
    apply(0, 32'h80000000, 32'h80000000, 16'h0, 0, 0);   // R1 negative overflow
    apply(0, 32'h7FFFFFFF, 32'h80000000, 16'h0, 0, 0);   // R1 mixed sign
    apply(1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0);          // R2 addu no trap
    apply(3, 32'h80000000, 32'h1, 16'h0, 0, 0);          // R2 subu no trap
    apply(2, 32'h80000000, 32'h1, 16'h0, 0, 0);          // R3 trap
    apply(2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 0, 0);   // R3 trap
    apply(2, 32'h00000005, 32'h00000009, 16'h0, 0, 0);   // R3 plain
    apply(0, 32'd1000, 32'h7FFFFFFF, 16'hFF9C, 1, 0);    // R4 -100
    apply(0, 32'h80000000, 32'h0, 16'hFFFF, 1, 0);       // R4 imm overflow, opB ignored
    apply(0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0001, 1, 0);// R4 imm overflow
    apply(7, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 1, 0);       // R4 slti
    apply(8, 32'h00000001, 32'h0, 16'hFFFF, 1, 0);       // R4 sltiu vs 0xFFFFFFFF
    apply(4, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001, 1, 0);// R5 andi zero-ext
    apply(5, 32'h12340000, 32'h0, 16'h8001, 1, 0);       // R5 ori
    apply(4, 32'hF0F0F0F0, 32'h3C3C3C3C, 16'h0, 0, 0);   // R5 and
    apply(6, 32'h12345678, 32'h0, 16'h0, 0, 0);          // R6 not
    apply(6, 32'h0, 32'h0, 16'h8000, 1, 0);              // R6 nor imm
    apply(7, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0);          // R7 signed true
    apply(8, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0);          // R7 unsigned false
    apply(7, 32'h5, 32'h5, 16'h0, 0, 0);                 // R7 equal
    apply(9, 32'h0, 32'h12345678, 16'h0, 0, 8);          // R8
    apply(9, 32'hAAAA, 32'h12345678, 16'hFFFF, 1, 0);    // R8 zero shift, imm ignored
    apply(9, 32'h0, 32'h00000013, 16'h0, 0, 31);         // R8 max
    apply(10, 32'h0, 32'h12345678, 16'h0, 0, 8);         // R9
    apply(10, 32'h0, 32'h80000000, 16'h0, 0, 31);        // R9 max
    apply(11, 32'h1, 32'h2, 16'h0, 0, 0);                // R10 undefined
    apply(15, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 0, 0);  // R10 undefined
    for (int i = 0; i < 3000; i++) begin
      int op; logic [31:0] a, b; bit isel;
      op = $urandom_range(0, 12);
      a = $urandom; b = $urandom;
      if (i % 3 == 0) b[31] = a[31];
      if (i % 3 == 1) b[31] = ~a[31];
      isel = $urandom_range(0, 1) == 1;
      apply(op, a, b, 16'($urandom), isel, $urandom_range(0, 31));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule